// File: doc/BRIEF.md
# Programmable Cube-Cover Evaluator

This block evaluates a multi-output two-level sum-of-products function held as a table of cubes. Each stored cube has an input part with one three-valued literal per input variable and an output part with one membership flag per output function. Several output functions can therefore share the same product terms within one stored cover.

Software, or a testbench, loads cubes through a write port and sets how many rows are active. A start pulse captures an input vertex. The block then visits one active cube per clock and ORs the output part of every cube whose input part covers the vertex into an accumulator. When the last active row has been visited, the block pulses done and presents the result. The result stays unchanged until the next evaluation completes.

Top module: `sop_cover_eval`

## Requirements
- R1: After reset, busy, done and result are all 0, the active row count is 0 and every table row holds the empty literal code, so no row can match.
- R2: Input literal codes are stored two bits per variable, with variable x(i+1) in field bits [2i+1:2i] and compared with vector bit i. Code 0 matches only when the variable is 0. Code 1 matches only when it is 1. Code 2 matches either value. A cube covers the vertex only when all of its fields match.
- R3: Literal code 3 is the empty literal. A cube that holds it in any field never contributes to the result, whatever the vector is.
- R4: Output membership is one bit per function, with function j at bit j (1 = the term belongs, 0 = it does not). Result bit j is 1 exactly when at least one active covering cube has membership bit j set.
- R5: A start accepted while idle with an active count c >= 1 raises busy for exactly c cycles. Done is asserted for one cycle at the clock edge c cycles after the start edge, together with the new result. With c = 0, done appears at the start edge itself, with an all-zero result and no busy cycle.
- R6: Table rows at an index equal to or above the active count have no effect on the result.
- R7: A count write above the table depth K (default 8) stores K.
- R8: A start while busy is ignored. The running scan keeps its captured vector and its length, and no extra evaluation follows it.
- R9: Table writes and count writes presented while busy are ignored.
- R10: The result changes only in the cycle in which done is asserted, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Table row write strobe |
| wrAddr | input | IW (3) | Row index to write |
| wrLits | input | 2*NUM_IN (12) | Literal codes of the row, 2 bits per variable |
| wrMask | input | NUM_OUT (4) | Output membership bits of the row |
| cntWrEn | input | 1 | Active row count write strobe |
| cntIn | input | CW (4) | New active row count |
| start | input | 1 | Begin an evaluation of vecIn |
| vecIn | input | NUM_IN (6) | Input vertex, captured on an accepted start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | NUM_OUT (4) | Evaluated outputs of the last finished scan |

## Verification
A wrong index or a wrong count compare shows up as a done pulse that is early or late against the programmed count, and the latency check of every run catches it on the first evaluation. A corrupted accumulator, a vector that is captured late or a faulty literal decode gives a wrong result word at that same done pulse. The full sweeps of both example covers expose it within one pass. A write or start that slips through while busy becomes visible only on the following evaluation, so those scenarios always rerun a known vertex and compare both the latency and the result.

// File: rtl/sop_cover_pkg.sv
package sop_cover_pkg;

  localparam logic [1:0] LIT_ZERO = 2'd0;
  localparam logic [1:0] LIT_ONE  = 2'd1;
  localparam logic [1:0] LIT_ANY  = 2'd2;
  localparam logic [1:0] LIT_VOID = 2'd3;

  typedef struct packed {
    logic tblWe;
    logic latchVec;
    logic clrAcc;
    logic accEn;
    logic loadRes;
    logic zeroRes;
  } ctrlStrobe_t;

endpackage

// File: rtl/sop_cube_match.sv
module sop_cube_match
  import sop_cover_pkg::*;
#(
  parameter int NUM_IN = 6
) (
  input  logic [2*NUM_IN-1:0] lits,
  input  logic [NUM_IN-1:0]   vec,
  output logic                hit
);

  logic [NUM_IN-1:0] posOk;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pos
    logic [1:0] code;
    assign code = lits[2*i +: 2];
    always_comb begin
      unique case (code)
        LIT_ZERO: posOk[i] = ~vec[i];
        LIT_ONE:  posOk[i] = vec[i];
        LIT_ANY:  posOk[i] = 1'b1;
        default:  posOk[i] = 1'b0;
      endcase
    end
  end

  assign hit = &posOk;

endmodule

// File: rtl/sop_cover_ctrl.sv
module sop_cover_ctrl
  import sop_cover_pkg::*;
#(
  parameter int NUM_CUBES = 8,
  parameter int IW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wrEn,
  input  logic          cntWrEn,
  input  logic [CW-1:0] cntIn,
  output ctrlStrobe_t   strb,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] CNT_MAX = CW'(NUM_CUBES);

  logic          busyR;
  logic          doneR;
  logic [CW-1:0] cntReg;
  logic [IW-1:0] idxR;
  logic          lastRow;
  logic          accept;

  assign lastRow = ((CW'(idxR) + CW'(1)) == cntReg);
  assign accept  = start & ~busyR;

  always_comb begin
    strb          = '0;
    strb.tblWe    = wrEn & ~busyR;
    strb.latchVec = accept;
    strb.clrAcc   = accept;
    strb.zeroRes  = accept & (cntReg == '0);
    strb.accEn    = busyR;
    strb.loadRes  = busyR & lastRow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      doneR  <= 1'b0;
      cntReg <= '0;
      idxR   <= '0;
    end else begin
      doneR <= 1'b0;
      if (!busyR) begin
        if (cntWrEn) begin
          cntReg <= (cntIn > CNT_MAX) ? CNT_MAX : cntIn;
        end
        if (start) begin
          idxR <= '0;
          if (cntReg == '0) begin
            doneR <= 1'b1;
          end else begin
            busyR <= 1'b1;
          end
        end
      end else begin
        if (lastRow) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end else begin
          idxR <= idxR + IW'(1);
        end
      end
    end
  end

  assign idx  = idxR;
  assign busy = busyR;
  assign done = doneR;

endmodule

// File: rtl/sop_cover_dp.sv
module sop_cover_dp
  import sop_cover_pkg::*;
#(
  parameter int NUM_IN = 6,
  parameter int NUM_OUT = 4,
  parameter int NUM_CUBES = 8,
  parameter int IW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [IW-1:0]       idx,
  input  logic [IW-1:0]       wrAddr,
  input  logic [2*NUM_IN-1:0] wrLits,
  input  logic [NUM_OUT-1:0]  wrMask,
  input  logic [NUM_IN-1:0]   vecIn,
  output logic [NUM_OUT-1:0]  result
);

  localparam int LW = 2 * NUM_IN;

  logic [LW-1:0]      litMem  [NUM_CUBES];
  logic [NUM_OUT-1:0] maskMem [NUM_CUBES];
  logic [NUM_IN-1:0]  vecReg;
  logic [NUM_OUT-1:0] acc;
  logic [NUM_OUT-1:0] resReg;
  logic [NUM_OUT-1:0] termOut;
  logic [LW-1:0]      curLits;
  logic [NUM_OUT-1:0] curMask;
  logic               hit;

  assign curLits = litMem[idx];
  assign curMask = maskMem[idx];

  sop_cube_match #(.NUM_IN(NUM_IN)) u_match (
    .lits (curLits),
    .vec  (vecReg),
    .hit  (hit)
  );

  assign termOut = hit ? curMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_CUBES; r++) begin
        litMem[r]  <= {NUM_IN{LIT_VOID}};
        maskMem[r] <= '0;
      end
    end else if (strb.tblWe && (int'(wrAddr) < NUM_CUBES)) begin
      litMem[wrAddr]  <= wrLits;
      maskMem[wrAddr] <= wrMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg <= '0;
      acc    <= '0;
      resReg <= '0;
    end else begin
      if (strb.latchVec) begin
        vecReg <= vecIn;
      end
      if (strb.clrAcc) begin
        acc <= '0;
      end else if (strb.accEn) begin
        acc <= acc | termOut;
      end
      if (strb.zeroRes) begin
        resReg <= '0;
      end else if (strb.loadRes) begin
        resReg <= acc | termOut;
      end
    end
  end

  assign result = resReg;

endmodule

// File: rtl/sop_cover_eval.sv
module sop_cover_eval
  import sop_cover_pkg::*;
#(
  parameter int NUM_IN = 6,
  parameter int NUM_OUT = 4,
  parameter int NUM_CUBES = 8,
  localparam int IW = (NUM_CUBES > 1) ? $clog2(NUM_CUBES) : 1,
  localparam int CW = $clog2(NUM_CUBES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IW-1:0]       wrAddr,
  input  logic [2*NUM_IN-1:0] wrLits,
  input  logic [NUM_OUT-1:0]  wrMask,
  input  logic                cntWrEn,
  input  logic [CW-1:0]       cntIn,
  input  logic                start,
  input  logic [NUM_IN-1:0]   vecIn,
  output logic                busy,
  output logic                done,
  output logic [NUM_OUT-1:0]  result
);

  ctrlStrobe_t   strb;
  logic [IW-1:0] idx;

  sop_cover_ctrl #(
    .NUM_CUBES (NUM_CUBES),
    .IW        (IW),
    .CW        (CW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wrEn    (wrEn),
    .cntWrEn (cntWrEn),
    .cntIn   (cntIn),
    .strb    (strb),
    .idx     (idx),
    .busy    (busy),
    .done    (done)
  );

  sop_cover_dp #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .NUM_CUBES (NUM_CUBES),
    .IW        (IW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .idx    (idx),
    .wrAddr (wrAddr),
    .wrLits (wrLits),
    .wrMask (wrMask),
    .vecIn  (vecIn),
    .result (result)
  );

endmodule

// File: rtl/sop_cover_chk.sv
module sop_cover_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [NUM_OUT-1:0] result
);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R5
  scan_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5
  launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy || done));

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) || $past(start)));

endmodule

bind sop_cover_eval sop_cover_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/sim_sop_cover_eval.sv
module sim_sop_cover_eval;

  localparam int NIN   = 6;
  localparam int NOUT  = 4;
  localparam int NCUBE = 8;
  localparam int IW    = 3;
  localparam int CW    = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [IW-1:0]   wrAddr = '0;
  logic [2*NIN-1:0] wrLits = '0;
  logic [NOUT-1:0] wrMask = '0;
  logic            cntWrEn = 1'b0;
  logic [CW-1:0]   cntIn = '0;
  logic            start = 1'b0;
  logic [NIN-1:0]  vecIn = '0;
  logic            busy;
  logic            done;
  logic [NOUT-1:0] result;

  int tests = 0;
  int fails = 0;

  logic [2*NIN-1:0] mLits [NCUBE];
  logic [NOUT-1:0]  mMask [NCUBE];
  int               mCount = 0;

  always #5 clk = ~clk;

  sop_cover_eval #(.NUM_IN(NIN), .NUM_OUT(NOUT), .NUM_CUBES(NCUBE)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrLits(wrLits),
    .wrMask(wrMask), .cntWrEn(cntWrEn), .cntIn(cntIn), .start(start),
    .vecIn(vecIn), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2*NIN-1:0] packL(input int c [NIN]);
    logic [2*NIN-1:0] p;
    for (int i = 0; i < NIN; i++) p[2*i +: 2] = 2'(c[i]);
    return p;
  endfunction

  function automatic logic [NOUT-1:0] model(input logic [NIN-1:0] v, input int cnt);
    logic [NOUT-1:0] r = '0;
    for (int k = 0; k < cnt; k++) begin
      bit ok = 1'b1;
      for (int i = 0; i < NIN; i++) begin
        case (mLits[k][2*i +: 2])
          2'd0: if (v[i]) ok = 1'b0;
          2'd1: if (!v[i]) ok = 1'b0;
          2'd2: ;
          default: ok = 1'b0;
        endcase
      end
      if (ok) r = r | mMask[k];
    end
    return r;
  endfunction

  task automatic writeCube(input int a, input int c [NIN], input logic [NOUT-1:0] m,
                           input bit track);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = IW'(a); wrLits = packL(c); wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
    if (track) begin
      mLits[a] = packL(c);
      mMask[a] = m;
    end
  endtask

  task automatic setCount(input int n);
    @(negedge clk);
    cntWrEn = 1'b1; cntIn = CW'(n);
    @(negedge clk);
    cntWrEn = 1'b0;
    mCount = (n > NCUBE) ? NCUBE : n;
  endtask

  // Start at a negedge, then count edges until done; result checked at done.
  task automatic runEval(input logic [NIN-1:0] v, input logic [NOUT-1:0] expRes,
                         input int expLat, input string req);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; vecIn = v;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == expLat, req, "latency", cyc, expLat);
    chk(result == expRes, req, "result", int'(result), int'(expRes));
    chk(!busy, req, "busy low at done", int'(busy), 0);
  endtask

  task automatic tReset();
    chk(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    chk(result == '0, "R1", "result after reset", int'(result), 0);
    // count 0 and empty table: immediate zero result
    runEval(6'h3f, '0, 0, "R1");
  endtask

  task automatic tSmallCover();
    for (int k = 0; k < NCUBE; k++) begin
      mLits[k] = {NIN{2'd3}};
      mMask[k] = '0;
    end
    writeCube(0, '{2, 0, 2, 2, 2, 2}, 4'b0001, 1);
    writeCube(1, '{1, 2, 0, 2, 2, 2}, 4'b0001, 1);
    writeCube(2, '{2, 1, 2, 2, 2, 2}, 4'b0010, 1);
    writeCube(3, '{0, 2, 0, 2, 2, 2}, 4'b0010, 1);
    setCount(4);
    // hand value: x1=x2=x3=1 -> only the x2 term of function 2
    runEval(6'b000111, 4'b0010, 4, "R2");
    // hand value: all zero -> x2'=1 for f1 and x1'x3' for f2
    runEval(6'b000000, 4'b0011, 4, "R4");
    for (int v = 0; v < 8; v++) runEval(6'(v), model(6'(v), 4), 4, "R4");
  endtask

  task automatic tPla();
    writeCube(0, '{2, 2, 1, 2, 2, 0}, 4'b0001, 1);
    writeCube(1, '{2, 1, 2, 0, 2, 2}, 4'b0010, 1);
    writeCube(2, '{1, 2, 2, 2, 2, 0}, 4'b1000, 1);
    writeCube(3, '{1, 2, 2, 2, 1, 2}, 4'b0010, 1);
    writeCube(4, '{0, 2, 2, 2, 2, 2}, 4'b0100, 1);
    writeCube(5, '{2, 2, 2, 2, 2, 1}, 4'b1000, 1);
    setCount(6);
    for (int v = 0; v < 64; v++) runEval(6'(v), model(6'(v), 6), 6, "R2");
  endtask

  task automatic tBeyondCount();
    writeCube(6, '{2, 2, 2, 2, 2, 2}, 4'b1111, 1);
    // all-zero vertex: only x1' term hits among the first six rows
    runEval(6'b000000, 4'b0100, 6, "R6");
    setCount(7);
    runEval(6'b000000, 4'b1111, 7, "R6");
  endtask

  task automatic tClamp();
    setCount(15);
    runEval(6'b000000, 4'b1111, 8, "R7");
  endtask

  task automatic tStartWhileBusy();
    int cyc = 0;
    int extra = 0;
    writeCube(6, '{2, 2, 3, 2, 2, 2}, 4'b1111, 1);
    @(negedge clk);
    start = 1'b1; vecIn = 6'b000000;
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin @(negedge clk); cyc++; end
    start = 1'b1; vecIn = 6'b100001;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk(cyc == 8, "R8", "latency with start while busy", cyc, 8);
    chk(result == 4'b0100, "R8", "result keeps first vector", int'(result), 4);
    repeat (6) begin @(negedge clk); if (done || busy) extra++; end
    chk(extra == 0, "R8", "no second scan", extra, 0);
  endtask

  task automatic tVoid();
    // row 6 holds code 3 with all-ones membership; it must never add bits
    runEval(6'b000000, 4'b0100, 8, "R3");
    runEval(6'b111111, model(6'b111111, 8), 8, "R3");
    chk(model(6'b000100, 8) != 4'b1111, "R3", "model sanity", 0, 0);
    runEval(6'b000100, model(6'b000100, 8), 8, "R3");
  endtask

  task automatic tWriteWhileBusy();
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; vecIn = 6'b000000;
    @(negedge clk);
    start = 1'b0;
    wrEn = 1'b1; wrAddr = 3'd4; wrLits = {NIN{2'd3}}; wrMask = '0;
    cntWrEn = 1'b1; cntIn = 4'd2;
    repeat (2) begin @(negedge clk); cyc++; end
    wrEn = 1'b0; cntWrEn = 1'b0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk(cyc == 8, "R9", "latency of scan with writes", cyc, 8);
    // rerun: row 4 and count must be unchanged
    runEval(6'b000000, 4'b0100, 8, "R9");
  endtask

  task automatic tHold();
    logic [NOUT-1:0] snap;
    runEval(6'b000001, model(6'b000001, 8), 8, "R10");
    snap = result;
    vecIn = 6'b111110;
    repeat (5) @(negedge clk);
    chk(result == snap, "R10", "result held after done", int'(result), int'(snap));
    setCount(0);
    runEval(6'b111111, 4'b0000, 0, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSmallCover();
    tPla();
    tBeyondCount();
    tClamp();
    tStartWhileBusy();
    tVoid();
    tWriteWhileBusy();
    tHold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule